// File: doc/BRIEF.md
# Execute-Stage ALU with Condition Flags and Branch Decision

This block is the arithmetic core of the execute stage of a small 32-bit processor. It takes two operands and a two-bit operation code, and it returns the result at once, with no clock in that path. The control logic drives the operands. For arithmetic and logic instructions the operands come from the register file. For effective addresses they are a base register and a displacement. For stack-pointer updates they are the pointer and a constant of plus or minus four.

The block owns a three-flag condition register: overflow, zero and sign. The flags load from the current result on a rising clock edge only while `set_cc_i` is high. The control logic asserts it for arithmetic and logic instructions only, so address and stack arithmetic use the adder without touching the flags.

A separate four-bit jump code is tested against the stored flags. It gives a taken/not-taken decision, and the control logic uses that decision to pick the branch target or the fall-through address.

Top module: `exe_unit`

## Requirements
- R1: With `alu_fn_i` = 0 (add), `val_e_o` equals `alu_b_i + alu_a_i` modulo 2^32 in the same cycle, including wrap-around when adding 0xFFFFFFFC (minus four) to a pointer.
- R2: With `alu_fn_i` = 1 (subtract), `val_e_o` equals `alu_b_i - alu_a_i` (second operand minus first) modulo 2^32.
- R3: With `alu_fn_i` = 2, `val_e_o` is the bitwise AND of the operands; with `alu_fn_i` = 3 it is the bitwise XOR.
- R4: On a rising edge with `set_cc_i` high, the zero flag (`cc_o[1]`) loads 1 exactly when the result is zero, and the sign flag (`cc_o[0]`) loads bit 31 of the result.
- R5: On the same edge the overflow flag (`cc_o[2]`) loads signed overflow. For add, it is set when both operands have the same sign and the result's sign differs. For subtract, it is set when `alu_b_i` and `alu_a_i` differ in sign and the result's sign differs from `alu_b_i`. AND and XOR clear it.
- R6: While `set_cc_i` is low, the flags keep their value whatever the operation and operands.
- R7: While `rst_ni` is low, and until the first flag update after it rises, `cc_o` is 3'b010 (zero flag set, overflow and sign clear).
- R8: `bch_o` is computed from the stored flags and `jmp_fn_i`, where lt = SF xor OF: code 0 always taken, 1 = lt or ZF, 2 = lt, 3 = ZF, 4 = not ZF, 5 = not lt, 6 = not lt and not ZF.
- R9: Jump codes 7 to 15 give `bch_o` = 0 for every flag value.
- R10: `bch_o` depends on the stored flags only: changing the operands or the operation with `set_cc_i` low leaves `bch_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, flags load on rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| alu_fn_i | input | 2 | Operation: 0 add, 1 subtract, 2 AND, 3 XOR |
| alu_a_i | input | 32 | First operand |
| alu_b_i | input | 32 | Second operand (minuend for subtract) |
| set_cc_i | input | 1 | Load flags from this cycle's result |
| jmp_fn_i | input | 4 | Jump condition code |
| val_e_o | output | 32 | Result |
| cc_o | output | 3 | Stored flags {overflow, zero, sign} |
| bch_o | output | 1 | Branch taken |

## Verification
On every cycle, the assertions check four things. The flags hold while `set_cc_i` is low. A flag load records the zero and sign of the previous cycle's result. A logic operation clears overflow. The decision is never taken for the unused jump codes and always taken for the unconditional code. Two things are left to the bench's scenarios: whether each result value is correct, and whether overflow is correct at the signed boundaries in both add and subtract order. The bench also sweeps all sixteen jump codes after every flag pattern it produces, and only that sweep can show that each condition decodes to the right flag combination.

// File: rtl/exe_pkg.sv
package exe_pkg;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2,
    ALU_XOR = 2'd3
  } alu_fn_e;

  typedef enum logic [3:0] {
    JC_ALW = 4'd0,
    JC_LE  = 4'd1,
    JC_LT  = 4'd2,
    JC_EQ  = 4'd3,
    JC_NE  = 4'd4,
    JC_GE  = 4'd5,
    JC_GT  = 4'd6
  } jmp_fn_e;

  typedef struct packed {
    logic of;
    logic zf;
    logic sf;
  } cc_t;

  localparam cc_t CC_RESET = '{of: 1'b0, zf: 1'b1, sf: 1'b0};
endpackage

// File: rtl/exe_alu.sv
module exe_alu #(
  parameter int unsigned W = exe_pkg::DATA_W
) (
  input  logic [1:0]   fn_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output exe_pkg::cc_t flg_o
);
  import exe_pkg::*;

  localparam int unsigned MSB = W - 1;

  logic [W-1:0] sum, dif;
  logic         ovf_add, ovf_sub;

  assign sum = b_i + a_i;
  assign dif = b_i - a_i;

  // signed overflow, operand order follows the subtraction (b - a)
  assign ovf_add = (a_i[MSB] == b_i[MSB]) && (sum[MSB] != a_i[MSB]);
  assign ovf_sub = (a_i[MSB] != b_i[MSB]) && (dif[MSB] != b_i[MSB]);

  always_comb begin
    unique case (alu_fn_e'(fn_i))
      ALU_ADD: res_o = sum;
      ALU_SUB: res_o = dif;
      ALU_AND: res_o = a_i & b_i;
      default: res_o = a_i ^ b_i;
    endcase
  end

  always_comb begin
    flg_o.zf = (res_o == '0);
    flg_o.sf = res_o[MSB];
    unique case (alu_fn_e'(fn_i))
      ALU_ADD: flg_o.of = ovf_add;
      ALU_SUB: flg_o.of = ovf_sub;
      default: flg_o.of = 1'b0;
    endcase
  end
endmodule

// File: rtl/exe_ccreg.sv
module exe_ccreg (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  exe_pkg::cc_t nxt_i,
  output exe_pkg::cc_t q_o
);
  import exe_pkg::*;

  cc_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= CC_RESET;
    else if (load_i) q <= nxt_i;
  end

  assign q_o = q;

  // R6: flags hold without a load
  a_r6_cc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q));
endmodule

// File: rtl/exe_brcond.sv
module exe_brcond (
  input  logic [3:0]   jfn_i,
  input  exe_pkg::cc_t cc_i,
  output logic         taken_o
);
  import exe_pkg::*;

  logic lt;
  assign lt = cc_i.sf ^ cc_i.of;

  always_comb begin
    unique case (jfn_i)
      JC_ALW:  taken_o = 1'b1;
      JC_LE:   taken_o = lt | cc_i.zf;
      JC_LT:   taken_o = lt;
      JC_EQ:   taken_o = cc_i.zf;
      JC_NE:   taken_o = ~cc_i.zf;
      JC_GE:   taken_o = ~lt;
      JC_GT:   taken_o = ~lt & ~cc_i.zf;
      default: taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/exe_unit.sv
module exe_unit #(
  parameter int unsigned DATA_W = exe_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        alu_fn_i,
  input  logic [DATA_W-1:0] alu_a_i,
  input  logic [DATA_W-1:0] alu_b_i,
  input  logic              set_cc_i,
  input  logic [3:0]        jmp_fn_i,
  output logic [DATA_W-1:0] val_e_o,
  output logic [2:0]        cc_o,
  output logic              bch_o
);
  import exe_pkg::*;

  cc_t flg_nxt, flg_q;

  exe_alu #(.W(DATA_W)) u_alu (
    .fn_i  (alu_fn_i),
    .a_i   (alu_a_i),
    .b_i   (alu_b_i),
    .res_o (val_e_o),
    .flg_o (flg_nxt)
  );

  exe_ccreg u_cc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (set_cc_i),
    .nxt_i  (flg_nxt),
    .q_o    (flg_q)
  );

  exe_brcond u_br (
    .jfn_i   (jmp_fn_i),
    .cc_i    (flg_q),
    .taken_o (bch_o)
  );

  assign cc_o = flg_q;

  // R4: a load records zero and sign of the previous result
  a_r4_zf_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_cc_i |=> (cc_o[1] == ($past(val_e_o) == '0)) && (cc_o[0] == $past(val_e_o[DATA_W-1])));

  // R5: logic operations clear overflow
  a_r5_logic_of: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_cc_i && alu_fn_i[1]) |=> !cc_o[2]);

  // R9: unused jump codes never branch
  a_r9_undef_jfn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jmp_fn_i > 4'd6) |-> !bch_o);

  // R8: unconditional code always branches
  a_r8_always: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jmp_fn_i == 4'd0) |-> bch_o);
endmodule

// File: tb/tb_exe_unit.sv
`timescale 1ns/1ps
module tb_exe_unit;
  typedef struct packed {
    logic [1:0]  fn;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] e;
    logic [2:0]  cc;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 32'h0000_0001, 32'h0000_0002, 32'h0000_0003, 3'b000},
    '{2'd0, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 3'b101},
    '{2'd0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 3'b010},
    '{2'd0, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 3'b110},
    '{2'd1, 32'h0000_0001, 32'h0000_0005, 32'h0000_0004, 3'b000},
    '{2'd1, 32'h0000_0005, 32'h0000_0001, 32'hFFFF_FFFC, 3'b001},
    '{2'd1, 32'h0000_0001, 32'h8000_0000, 32'h7FFF_FFFF, 3'b100},
    '{2'd1, 32'h8000_0000, 32'h0000_0000, 32'h8000_0000, 3'b101},
    '{2'd1, 32'h0000_1234, 32'h0000_1234, 32'h0000_0000, 3'b010},
    '{2'd2, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'hF000_F000, 3'b001},
    '{2'd3, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 32'h0000_0000, 3'b010},
    '{2'd3, 32'h0000_FFFF, 32'h8000_FF00, 32'h8000_00FF, 3'b001}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  alu_fn = '0;
  logic [31:0] alu_a = '0, alu_b = '0;
  logic        set_cc = 1'b0;
  logic [3:0]  jmp_fn = '0;
  logic [31:0] val_e;
  logic [2:0]  cc;
  logic        bch;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  exe_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .alu_fn_i(alu_fn), .alu_a_i(alu_a), .alu_b_i(alu_b),
    .set_cc_i(set_cc), .jmp_fn_i(jmp_fn), .val_e_o(val_e), .cc_o(cc), .bch_o(bch)
  );

  // branch model from R8/R9, flags {of,zf,sf}
  function automatic logic exp_bch(input logic [2:0] f, input logic [3:0] j);
    logic lt;
    lt = f[0] ^ f[2];
    case (j)
      4'd0: return 1'b1;
      4'd1: return lt | f[1];
      4'd2: return lt;
      4'd3: return f[1];
      4'd4: return !f[1];
      4'd5: return !lt;
      4'd6: return !lt && !f[1];
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sweep_jumps(input logic [2:0] f);
    for (int j = 0; j < 16; j++) begin
      jmp_fn = 4'(j);
      #0.2;
      check((j > 6) ? "R9" : "R8", {31'd0, bch}, {31'd0, exp_bch(f, 4'(j))});
    end
  endtask

  // drive at negedge, check result, load flags, check flags
  task automatic apply(input logic [1:0] fn, input logic [31:0] a, input logic [31:0] b,
                       input logic ld, input string req, input logic [31:0] e);
    @(negedge clk);
    alu_fn = fn; alu_a = a; alu_b = b; set_cc = ld;
    #0.5;
    check(req, val_e, e);
    @(posedge clk);
    #0.5;
    set_cc = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [2:0] held;
    // R7 reset state
    #5;
    check("R7", {29'd0, cc}, 32'h2);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R7", {29'd0, cc}, 32'h2);
    sweep_jumps(3'b010);

    // table: R1/R2/R3 results, R4/R5 flags, R8/R9 sweep
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].fn, VECS[i].a, VECS[i].b, 1'b1,
            (VECS[i].fn == 2'd0) ? "R1" : (VECS[i].fn == 2'd1) ? "R2" : "R3", VECS[i].e);
      check((VECS[i].cc[2] != 1'b0 || VECS[i].fn == 2'd1) ? "R5" : "R4", {29'd0, cc}, {29'd0, VECS[i].cc});
      sweep_jumps(VECS[i].cc);
    end

    // R5: logic op clears overflow left by add
    apply(2'd0, 32'h4000_0000, 32'h4000_0000, 1'b1, "R1", 32'h8000_0000);
    check("R5", {29'd0, cc}, 32'h5);
    apply(2'd2, 32'h8000_0001, 32'hFFFF_FFFF, 1'b1, "R3", 32'h8000_0001);
    check("R5", {29'd0, cc}, 32'h1);

    // R6: stack adjust by -4 and +4 and address add keep flags
    held = cc;
    apply(2'd0, 32'hFFFF_FFFC, 32'h0000_0100, 1'b0, "R1", 32'h0000_00FC);
    check("R6", {29'd0, cc}, {29'd0, held});
    apply(2'd0, 32'h0000_0004, 32'hFFFF_FFFC, 1'b0, "R1", 32'h0000_0000);
    check("R6", {29'd0, cc}, {29'd0, held});
    apply(2'd1, 32'h0000_0001, 32'h8000_0000, 1'b0, "R2", 32'h7FFF_FFFF);
    check("R6", {29'd0, cc}, {29'd0, held});

    // R10: operands change with no load, decision stays
    jmp_fn = 4'd2;
    #0.2;
    check("R10", {31'd0, bch}, 32'h1);
    @(negedge clk);
    alu_fn = 2'd3; alu_a = 32'h0; alu_b = 32'h0;
    #0.5;
    check("R10", {31'd0, bch}, 32'h1);
    @(posedge clk); #0.5;
    check("R10", {31'd0, bch}, 32'h1);

    // R7: asynchronous reset restores flags mid-run
    @(negedge clk); rst_n = 1'b0;
    #0.5;
    check("R7", {29'd0, cc}, 32'h2);
    @(negedge clk); rst_n = 1'b1;
    sweep_jumps(3'b010);

    finish_run();
  end
endmodule